// File: doc/BRIEF.md
# Signed and Fractional 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product as a high byte and a low byte, together with a carry flag and a zero flag. Each operand can be taken as unsigned or as two's complement. Three signedness pairings are offered: both unsigned, both signed, and a signed first operand with an unsigned second. Each pairing has an integer form and a fractional form. The fractional form returns the product shifted left by one bit, which keeps the result in the same fixed-point format as the inputs.

A caller presents the operands and a mode code with a one-cycle start pulse. The block captures them on that clock edge. It then reports the result with a one-cycle valid strobe two cycles after the start cycle. The result and flags hold their values until the next result is produced. A new operation may start in the same cycle as the valid strobe, so one multiply completes every two cycles. A start pulse in the cycle between capture and result is dropped. Placing the result in a register file is left to the caller.

Top module: `fmul_unit`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o`, `flag_z_o`, `flag_c_o`, `prod_hi_o` and `prod_lo_o` are all zero until the first result.
- R2: A start accepted in clock cycle c captures `opa_i`, `opb_i` and `mode_i` in that cycle. It raises `valid_o` for exactly one cycle, in cycle c+2, with the result of the captured values. `valid_o` is low in cycle c+1.
- R3: A start in the cycle after an accepted start is ignored: it does not disturb the pending result and produces no second valid strobe. A start in the valid cycle itself is accepted.
- R4: The field `mode_i[1:0]` selects signedness: 00 means both unsigned, 01 means both signed, 10 means `opa_i` signed and `opb_i` unsigned, and 11 behaves as 00. `mode_i[2]`=1 selects the fractional form.
- R5: In integer form, {`prod_hi_o`,`prod_lo_o`} is the low 16 bits of the exact product of the operands as interpreted by the mode.
- R6: In fractional form, the result is the low 16 bits of the exact product shifted left by one bit, so bit 0 of `prod_lo_o` is zero.
- R7: `flag_c_o` equals bit 15 of the 16-bit product taken before any fractional shift.
- R8: `flag_z_o` is 1 exactly when the delivered 16-bit result is zero.
- R9: Between valid strobes, the product and flag outputs keep the values delivered with the most recent strobe.
- R10: Signed fractional 0x80 times 0x80 wraps to 0x8000 with `flag_c_o`=0 and `flag_z_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; operands and mode are sampled with it |
| mode_i | input | 3 | Bit 2 selects fractional form; bits 1:0 select signedness |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Upper byte of the result |
| prod_lo_o | output | 8 | Lower byte of the result |
| flag_z_o | output | 1 | Result-is-zero flag |
| flag_c_o | output | 1 | Bit 15 of the unshifted product |
| valid_o | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The situation hardest to reach from the ports is a start pulse that arrives in the single cycle between capture and result. It must change neither the pending result nor the strobe pattern. The stimulus sends such a pulse with unrelated operands on a random subset of operations. It then checks that the strobe stays low in the following cycle and that the outputs hold. Back-to-back starts placed in the valid cycle are mixed in at random, and the corner products run directed: 0x80 squared in fractional signed form, 0xFF squared, and zero operands.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  // signedness selection, taken from mode_i[1:0]
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_ALT = 2'b11
  } sgn_mode_e;

  localparam int unsigned MODE_W   = 3;
  localparam int unsigned FRAC_BIT = 2;

endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic valid_o
);

  logic busy_q, busy_d;
  logic valid_q, valid_d;

  assign accept_o = start_i & ~busy_q;

  always_comb begin
    busy_d  = accept_o;
    valid_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/fmul_operand_prep.sv
module fmul_operand_prep
  import fmul_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned EW = W + 1
) (
  input  logic [1:0]   sgn_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [EW-1:0] a_ext_o,
  output logic [EW-1:0] b_ext_o
);

  logic a_signed, b_signed;

  always_comb begin
    unique case (sgn_mode_e'(sgn_i))
      SGN_SS:  begin a_signed = 1'b1; b_signed = 1'b1; end
      SGN_SU:  begin a_signed = 1'b1; b_signed = 1'b0; end
      default: begin a_signed = 1'b0; b_signed = 1'b0; end
    endcase
  end

  assign a_ext_o = {a_signed & opa_i[W-1], opa_i};
  assign b_ext_o = {b_signed & opb_i[W-1], opb_i};

endmodule

// File: rtl/fmul_array.sv
module fmul_array #(
  parameter int unsigned W  = 8,
  localparam int unsigned EW = W + 1,
  localparam int unsigned PW = 2 * W
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  output logic [PW-1:0] prod_o
);

  logic [PW-1:0] a_sx;
  logic [PW-1:0] rows [EW];

  assign a_sx = {{(PW-EW){a_i[EW-1]}}, a_i};

  // rows below the top carry positive weight; the top bit of b is negative
  for (genvar i = 0; i < EW; i++) begin : g_row
    if (i < EW - 1) begin : g_pos
      assign rows[i] = b_i[i] ? (a_sx << i) : '0;
    end else begin : g_neg
      assign rows[i] = b_i[i] ? (~(a_sx << i) + 1'b1) : '0;
    end
  end

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < EW; k++) begin
      prod_o = prod_o + rows[k];
    end
  end

endmodule

// File: rtl/fmul_format.sv
module fmul_format #(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] raw_i,
  input  logic          frac_i,
  output logic [PW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o
);

  always_comb begin
    carry_o = raw_i[PW-1];
    res_o   = frac_i ? {raw_i[PW-2:0], 1'b0} : raw_i;
    zero_o  = (res_o == '0);
  end

endmodule

// File: rtl/fmul_unit.sv
module fmul_unit
  import fmul_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned EW = W + 1,
  localparam int unsigned PW = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [W-1:0]      prod_hi_o,
  output logic [W-1:0]      prod_lo_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              valid_o
);

  logic          accept, busy;
  logic [EW-1:0] a_ext, b_ext;
  logic [EW-1:0] a_q, a_d, b_q, b_d;
  logic          frac_q, frac_d;
  logic [PW-1:0] raw, res;
  logic          c_n, z_n;
  logic [PW-1:0] res_q, res_d;
  logic          z_q, z_d, c_q, c_d;

  fmul_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .valid_o  (valid_o)
  );

  fmul_operand_prep #(.W(W)) u_prep (
    .sgn_i   (mode_i[1:0]),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .a_ext_o (a_ext),
    .b_ext_o (b_ext)
  );

  // capture stage, enabled by an accepted start
  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    frac_d = frac_q;
    if (accept) begin
      a_d    = a_ext;
      b_d    = b_ext;
      frac_d = mode_i[FRAC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      frac_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      frac_q <= frac_d;
    end
  end

  fmul_array #(.W(W)) u_array (
    .a_i    (a_q),
    .b_i    (b_q),
    .prod_o (raw)
  );

  fmul_format #(.W(W)) u_fmt (
    .raw_i   (raw),
    .frac_i  (frac_q),
    .res_o   (res),
    .carry_o (c_n),
    .zero_o  (z_n)
  );

  // result stage, enabled in the cycle after capture
  always_comb begin
    res_d = res_q;
    z_d   = z_q;
    c_d   = c_q;
    if (busy) begin
      res_d = res;
      z_d   = z_n;
      c_d   = c_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else begin
      res_q <= res_d;
      z_q   <= z_d;
      c_q   <= c_d;
    end
  end

  assign prod_hi_o = res_q[PW-1:W];
  assign prod_lo_o = res_q[W-1:0];
  assign flag_z_o  = z_q;
  assign flag_c_o  = c_q;

endmodule

// File: rtl/fmul_unit_chk.sv
module fmul_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         accept,
  input logic         busy,
  input logic         frac_q,
  input logic [W-1:0] prod_hi_o,
  input logic [W-1:0] prod_lo_o,
  input logic         flag_z_o,
  input logic         flag_c_o,
  input logic         valid_o
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 valid_o);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |-> ##2 !valid_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (flag_z_o == ({prod_hi_o, prod_lo_o} == '0)));

  p_frac_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frac_q) |=> (prod_lo_o[0] == 1'b0));

  p_carry_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frac_q) |=> (flag_c_o == prod_hi_o[W-1]));

endmodule

bind fmul_unit fmul_unit_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .accept    (accept),
  .busy      (busy),
  .frac_q    (frac_q),
  .prod_hi_o (prod_hi_o),
  .prod_lo_o (prod_lo_o),
  .flag_z_o  (flag_z_o),
  .flag_c_o  (flag_c_o),
  .valid_o   (valid_o)
);

// File: tb/fmul_unit_tb_top.sv
`timescale 1ns/1ps
module fmul_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [2:0] mode_i;
  logic [7:0] opa_i, opb_i;
  logic [7:0] prod_hi_o, prod_lo_o;
  logic       flag_z_o, flag_c_o, valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fmul_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .prod_hi_o (prod_hi_o),
    .prod_lo_o (prod_lo_o),
    .flag_z_o  (flag_z_o),
    .flag_c_o  (flag_c_o),
    .valid_o   (valid_o)
  );

  // returns {carry, zero, result[15:0]}
  function automatic logic [17:0] ref_mul(logic [2:0] m, logic [7:0] a, logic [7:0] b);
    int ai, bi, p;
    logic [15:0] raw, res;
    bit sa, sb;
    sa = (m[1:0] == 2'b01) || (m[1:0] == 2'b10);
    sb = (m[1:0] == 2'b01);
    ai = sa ? {{24{a[7]}}, a} : {24'b0, a};
    bi = sb ? {{24{b[7]}}, b} : {24'b0, b};
    p   = ai * bi;
    raw = p[15:0];
    res = m[2] ? {raw[14:0], 1'b0} : raw;
    return {raw[15], (res == 16'h0), res};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the falling edge of the valid cycle
  task automatic run_op(logic [2:0] m, logic [7:0] a, logic [7:0] b, bit poke, string tag);
    logic [17:0] e;
    e = ref_mul(m, a, b);
    mode_i = m; opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    check({tag, " R2 no early valid"}, {31'b0, valid_o}, 32'd0);
    if (poke) begin
      start_i = 1'b1;
      mode_i = ~m; opa_i = ~a; opb_i = b + 8'd7;
    end else begin
      start_i = 1'b0;
    end
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R2 valid"}, {31'b0, valid_o}, 32'd1);
    check({tag, " R5/R6 result"}, {16'b0, prod_hi_o, prod_lo_o}, {16'b0, e[15:0]});
    check({tag, " R7 carry"}, {31'b0, flag_c_o}, {31'b0, e[17]});
    check({tag, " R8 zero"}, {31'b0, flag_z_o}, {31'b0, e[16]});
    if (poke) begin
      @(negedge clk);
      check({tag, " R3 ignored start"}, {31'b0, valid_o}, 32'd0);
      check({tag, " R9 hold"}, {14'b0, flag_c_o, flag_z_o, prod_hi_o, prod_lo_o},
            {14'b0, e[17], e[16], e[15:0]});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; start_i = 1'b0; mode_i = 3'b0; opa_i = 8'h0; opb_i = 8'h0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, valid_o}, 32'd0);
    check("R1 reset outputs", {22'b0, prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {21'b0, valid_o, prod_hi_o, prod_lo_o, flag_z_o, flag_c_o}, 32'd0);

    // directed corners
    run_op(3'b101, 8'h80, 8'h80, 1'b0, "R10 frac signed 0x80^2");
    check("R10 value", {16'b0, prod_hi_o, prod_lo_o}, 32'h8000);
    check("R10 carry", {31'b0, flag_c_o}, 32'd0);
    run_op(3'b000, 8'hFF, 8'hFF, 1'b0, "R5 uu FF^2");
    check("R7 uu FF^2 carry set", {31'b0, flag_c_o}, 32'd1);
    run_op(3'b100, 8'hFF, 8'hFF, 1'b0, "R6 frac uu FF^2");
    check("R6 frac uu FF^2 value", {16'b0, prod_hi_o, prod_lo_o}, 32'hFC02);
    run_op(3'b010, 8'hFF, 8'hFF, 1'b0, "R4 su -1x255");
    check("R4 su value", {16'b0, prod_hi_o, prod_lo_o}, 32'hFF01);
    run_op(3'b001, 8'h00, 8'h9A, 1'b1, "R8 zero operand");
    check("R8 zero flag set", {31'b0, flag_z_o}, 32'd1);
    run_op(3'b011, 8'hC3, 8'h81, 1'b0, "R4 mode 11 as unsigned");
    check("R4 mode 11 value", {16'b0, prod_hi_o, prod_lo_o}, 32'(16'hC3 * 16'h81));
    @(negedge clk);

    // random mix: back-to-back starts in the valid cycle, pokes while busy, idle gaps
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      logic [7:0] a, b;
      bit poke;
      m = 3'($urandom_range(0, 7));
      a = 8'($urandom);
      b = 8'($urandom);
      if ($urandom_range(0, 7) == 0) a = 8'h80;
      if ($urandom_range(0, 7) == 0) b = 8'h00;
      poke = ($urandom_range(0, 3) == 0);
      run_op(m, a, b, poke, "R5 random");
      if ($urandom_range(0, 1) == 0 && !poke) @(negedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule